// File: doc/BRIEF.md
# Threshold Alarm and Interrupt Signaler

This block watches a signed charge count and a signed fine-resolution temperature reading, and compares them against four host-programmed limits: a high and a low charge limit, and a high and a low temperature limit. The temperature limits are given in whole degrees. The reading has three fractional bits, so each limit is scaled by eight before the comparison. The four tests are ORed into one alarm condition. When that condition goes from false to true while interrupts are enabled, the block raises one interrupt.

The interrupt goes out on one of two outputs, chosen by a select input. In the first style, the block holds the shared serial data line low for a long interval. Every device on the line decodes this as a bus reset. The interval length depends on the bus speed mode. In the second style, the block pulls a general-purpose open-drain pin low and keeps it low until the host writes 1 to the pin control bit.

When interrupts are not routed to the pin, the same pin control bit gives plain open-drain output and input sensing. Sleep, or an over-long low on the bus, releases the pin. The serial protocol engine drives the write strobes, the bus-reset and idle indications and the speed mode. The measurement logic supplies the two register values.

Top module: `alarm_irq`

## Requirements
- R1: The `alarm` output goes to 1 one cycle after any of the four limit tests is true, and goes back to 0 one cycle after all four are false.
- R2: The charge tests are signed 16-bit comparisons and include equality: charge ≥ high limit, or charge ≤ low limit.
- R3: The temperature tests compare the 11-bit signed reading against each 8-bit signed limit multiplied by 8, with equality included. For a high limit of 50, a reading of 400 trips the test and 399 does not.
- R4: `irq_en` resets to 0. A write with `en_wr`=1 loads `en_wdata`. `bus_reset` clears the bit one cycle later and wins over a write in the same cycle. No interrupt fires while the bit is 0.
- R5: With `route_bus`=1 an interrupt drives only `bus_pull`. With `route_bus`=0 it drives only `pin_pull`. The pin goes low one cycle after the alarm edge.
- R6: A bus interrupt keeps `bus_pull` high for exactly STD_LOW_CYC cycles when `overdrive`=0, and for OVD_LOW_CYC cycles when `overdrive`=1.
- R7: A bus interrupt starts only in a cycle where `bus_idle`=1. Until then it stays pending. A bus reset, disabling interrupts, or sleep drops the pending interrupt.
- R8: A pin interrupt keeps `pin_pull` at 1 until a host write with `pin_wr`=1 and `pin_wdata`=1.
- R9: A host write of 0 to the pin bit drives `pin_pull` to 1, and a write of 1 releases it. `pin_level` always reports the sensed pin input.
- R10: With `asleep`=1 or `bus_low_to`=1, the pin bit is forced to 1 (`pin_pull`=0) from the next cycle on. `asleep` also ends any bus pulse at once.
- R11: Each false-to-true transition of the alarm condition fires at most one interrupt. The condition must go false before another can fire.
- R12: If a pin interrupt fires in the same cycle as a host write of 1 to the pin bit, the interrupt wins and the pin stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| charge | input | 16 | Signed charge count |
| temp | input | 11 | Signed temperature, 0.125 °C per LSB |
| chg_hi | input | 16 | Signed charge high limit |
| chg_lo | input | 16 | Signed charge low limit |
| tmp_hi | input | 8 | Signed temperature high limit, 1 °C per LSB |
| tmp_lo | input | 8 | Signed temperature low limit, 1 °C per LSB |
| en_wr | input | 1 | Host write strobe for the interrupt enable bit |
| en_wdata | input | 1 | Value to write to the interrupt enable bit |
| route_bus | input | 1 | 1: interrupt on the bus line; 0: interrupt on the pin |
| bus_reset | input | 1 | A bus reset was seen |
| bus_idle | input | 1 | Bus high and no transaction in progress |
| overdrive | input | 1 | Fast bus timing selected |
| asleep | input | 1 | Device is in sleep |
| bus_low_to | input | 1 | Bus has been low beyond the sleep timeout |
| pin_wr | input | 1 | Host write strobe for the pin control bit |
| pin_wdata | input | 1 | Value to write to the pin control bit |
| pin_in | input | 1 | Sensed level of the pin |
| bus_pull | output | 1 | Drive the bus data line low |
| pin_pull | output | 1 | Drive the pin low |
| pin_level | output | 1 | Pin level returned on a read of the pin bit |
| irq_en | output | 1 | Interrupt enable bit |
| alarm | output | 1 | Registered alarm condition |

## Verification
Two kinds of update can land on the pin control bit in the same cycle: a pin interrupt that clears it, and a host write of 1 that sets it. The bench raises the temperature onto its high limit in the same cycle as it strobes a write of 1. It then expects the pin to stay low, and it also follows this on every clock through its reference model. Bus reset against an enable write, and sleep against a running bus pulse, are provoked the same way and judged by the same model.

// File: rtl/alarm_irq.sv
module alarm_irq #(
  parameter int CHG_W       = 16,
  parameter int TMP_W       = 11,
  parameter int THR_W       = 8,
  parameter int FRAC        = 3,
  parameter int STD_LOW_CYC = 40,
  parameter int OVD_LOW_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CHG_W-1:0] charge,
  input  logic [TMP_W-1:0] temp,
  input  logic [CHG_W-1:0] chg_hi,
  input  logic [CHG_W-1:0] chg_lo,
  input  logic [THR_W-1:0] tmp_hi,
  input  logic [THR_W-1:0] tmp_lo,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             route_bus,
  input  logic             bus_reset,
  input  logic             bus_idle,
  input  logic             overdrive,
  input  logic             asleep,
  input  logic             bus_low_to,
  input  logic             pin_wr,
  input  logic             pin_wdata,
  input  logic             pin_in,
  output logic             bus_pull,
  output logic             pin_pull,
  output logic             pin_level,
  output logic             irq_en,
  output logic             alarm
);
  localparam int TW    = ((TMP_W > THR_W + FRAC) ? TMP_W : THR_W + FRAC) + 1;
  localparam int CNT_W = $clog2(STD_LOW_CYC + 1);

  logic signed [TW-1:0] t_val, t_hi, t_lo;
  logic alarm_now, rise, fire, new_bus, launch, kill_pend;
  logic pend, act, pin_ctl;
  logic [CNT_W-1:0] cnt;

  assign t_val = TW'($signed(temp));
  assign t_hi  = TW'($signed({tmp_hi, {FRAC{1'b0}}}));
  assign t_lo  = TW'($signed({tmp_lo, {FRAC{1'b0}}}));

  assign alarm_now = ($signed(charge) >= $signed(chg_hi)) ||
                     ($signed(charge) <= $signed(chg_lo)) ||
                     (t_val >= t_hi) || (t_val <= t_lo);

  assign rise      = alarm_now & ~alarm;
  assign fire      = rise & irq_en & ~asleep;
  assign new_bus   = fire & route_bus;
  assign kill_pend = asleep | bus_reset | (en_wr & ~en_wdata);
  assign launch    = (pend | new_bus) & bus_idle & ~act & ~kill_pend & irq_en;

  assign bus_pull  = act;
  assign pin_pull  = ~pin_ctl;
  assign pin_level = pin_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm  <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      alarm <= alarm_now;
      if (bus_reset)   irq_en <= 1'b0;
      else if (en_wr)  irq_en <= en_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      act  <= 1'b0;
      cnt  <= '0;
    end else begin
      if (kill_pend)   pend <= 1'b0;
      else             pend <= (pend | new_bus) & ~launch;
      if (asleep) begin
        act <= 1'b0;
      end else if (act) begin
        if (cnt == '0) act <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end else if (launch) begin
        act <= 1'b1;
        cnt <= overdrive ? CNT_W'(OVD_LOW_CYC - 1) : CNT_W'(STD_LOW_CYC - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pin_ctl <= 1'b1;
    else if (asleep || bus_low_to)  pin_ctl <= 1'b1;
    else if (fire && !route_bus)    pin_ctl <= 1'b0;
    else if (pin_wr)                pin_ctl <= pin_wdata;
  end

  logic [CNT_W:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run <= '0;
    else if (act) run <= run + 1'b1;
    else          run <= '0;
  end

  p_pulse_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run <= (CNT_W+1)'(STD_LOW_CYC));
  p_launch_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_pull) |-> $past(bus_idle));
  p_launch_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_pull) |-> $past(irq_en));
  p_en_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !irq_en);
  p_pin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pull && !(pin_wr && pin_wdata) && !asleep && !bus_low_to) |=> pin_pull);
  p_sleep_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep || bus_low_to) |=> !pin_pull);
  p_sleep_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> !bus_pull);
  p_one_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_pull) |-> $past(route_bus));
endmodule

// File: tb/alarm_irq_tb.sv
module alarm_irq_tb;
  localparam int STD = 40;
  localparam int OVD = 5;

  logic clk = 0, rst_n = 0;
  logic [15:0] charge = 0, chg_hi = 16'd1000, chg_lo = -16'sd1000;
  logic [10:0] temp = 11'd200;
  logic [7:0]  tmp_hi = 8'd50, tmp_lo = -8'sd10;
  logic en_wr = 0, en_wdata = 0, route_bus = 0, bus_reset = 0, bus_idle = 1;
  logic overdrive = 0, asleep = 0, bus_low_to = 0, pin_wr = 0, pin_wdata = 0;
  logic ext_pull = 0;
  logic pin_in, bus_pull, pin_pull, pin_level, irq_en, alarm;
  int compared = 0, mismatched = 0;
  bit done = 0;

  assign pin_in = ~pin_pull & ~ext_pull;

  alarm_irq #(.STD_LOW_CYC(STD), .OVD_LOW_CYC(OVD)) u_dut (
    .clk, .rst_n, .charge, .temp, .chg_hi, .chg_lo, .tmp_hi, .tmp_lo,
    .en_wr, .en_wdata, .route_bus, .bus_reset, .bus_idle, .overdrive,
    .asleep, .bus_low_to, .pin_wr, .pin_wdata, .pin_in,
    .bus_pull, .pin_pull, .pin_level, .irq_en, .alarm);

  always #10 clk = ~clk;

  // behavioural reference model
  int m_alarm, m_en, m_pend, m_left, m_pin_low;
  always @(posedge clk) begin
    int cond, fire, go, kill;
    if (!rst_n) begin
      m_alarm = 0; m_en = 0; m_pend = 0; m_left = 0; m_pin_low = 0;
    end else begin
      cond = ($signed(charge) >= $signed(chg_hi)) || ($signed(charge) <= $signed(chg_lo)) ||
             ($signed(temp) >= $signed(tmp_hi) * 8) || ($signed(temp) <= $signed(tmp_lo) * 8);
      fire = cond && !m_alarm && m_en && !asleep;
      kill = asleep || bus_reset || (en_wr && !en_wdata);
      go = (m_pend || (fire && route_bus)) && bus_idle && m_left == 0 && !kill && m_en;
      if (asleep) m_left = 0;
      else if (m_left > 0) m_left--;
      else if (go) m_left = overdrive ? OVD : STD;
      if (kill) m_pend = 0;
      else m_pend = (m_pend || (fire && route_bus)) && !go;
      if (asleep || bus_low_to) m_pin_low = 0;
      else if (fire && !route_bus) m_pin_low = 1;
      else if (pin_wr) m_pin_low = !pin_wdata;
      if (bus_reset) m_en = 0; else if (en_wr) m_en = en_wdata;
      m_alarm = cond;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk(alarm,     m_alarm != 0,          "R1 alarm");
      chk(irq_en,    m_en != 0,             "R4 irq_en");
      chk(bus_pull,  m_left > 0,            "R6 bus_pull");
      chk(pin_pull,  m_pin_low != 0,        "R8 pin_pull");
      chk(pin_level, !m_pin_low && !ext_pull, "R9 pin_level");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    int n;
    tick(3); rst_n = 1; tick(1);
    chk(pin_pull, 0, "R8 reset"); chk(bus_pull, 0, "R6 reset"); chk(irq_en, 0, "R4 reset");
    en_wr = 1; en_wdata = 1; tick(1); en_wr = 0;
    chk(irq_en, 1, "R4 enable write");
    // charge high via pin
    charge = 16'd1000; tick(1);
    chk(pin_pull, 1, "R2 charge at high limit"); chk(bus_pull, 0, "R5 pin route");
    chk(alarm, 1, "R1 alarm up");
    tick(5); chk(pin_pull, 1, "R8 sticky");
    pin_wr = 1; pin_wdata = 1; tick(1); pin_wr = 0;
    chk(pin_pull, 0, "R8 released");
    tick(3); chk(pin_pull, 0, "R11 no refire while high");
    charge = 0; tick(2); chk(alarm, 0, "R1 alarm down");
    charge = -16'sd1000; tick(1); chk(pin_pull, 1, "R2 charge at low limit");
    pin_wr = 1; tick(1); pin_wr = 0; charge = 0; tick(2);
    // temperature scaling
    temp = 11'd399; tick(2); chk(pin_pull, 0, "R3 just below high");
    temp = 11'd400; tick(1); chk(pin_pull, 1, "R3 at high");
    pin_wr = 1; tick(1); pin_wr = 0; temp = 11'd200; tick(2);
    temp = -11'sd80; tick(1); chk(pin_pull, 1, "R3 at low");
    pin_wr = 1; tick(1); pin_wr = 0; temp = 11'd200; tick(2);
    // same-cycle interrupt and release write
    temp = 11'd400; pin_wr = 1; pin_wdata = 1; tick(1); pin_wr = 0;
    chk(pin_pull, 1, "R12 interrupt beats release");
    pin_wr = 1; tick(1); pin_wr = 0; temp = 11'd200; tick(2);
    // general-purpose pin
    en_wr = 1; en_wdata = 0; tick(1); en_wr = 0;
    pin_wr = 1; pin_wdata = 0; tick(1); pin_wr = 0;
    chk(pin_pull, 1, "R9 drive low"); chk(pin_level, 0, "R9 sense low");
    pin_wr = 1; pin_wdata = 1; tick(1); pin_wr = 0;
    chk(pin_pull, 0, "R9 release"); chk(pin_level, 1, "R9 sense high");
    ext_pull = 1; #1; chk(pin_level, 0, "R9 external low"); ext_pull = 0;
    charge = 16'd1000; tick(1); chk(pin_pull, 0, "R4 disabled no fire");
    charge = 0; tick(2);
    // bus route
    en_wr = 1; en_wdata = 1; tick(1); en_wr = 0;
    route_bus = 1; bus_idle = 0; charge = 16'd1000; tick(4);
    chk(bus_pull, 0, "R7 waits for idle");
    bus_idle = 1; tick(1);
    chk(bus_pull, 1, "R7 launch"); chk(pin_pull, 0, "R5 bus route");
    n = 0; while (bus_pull) begin n++; tick(1); end
    chk(n == STD, 1, "R6 standard length");
    charge = 0; tick(2);
    overdrive = 1; charge = 16'd1000; tick(1);
    n = 0; while (bus_pull) begin n++; tick(1); end
    chk(n == OVD, 1, "R6 overdrive length");
    charge = 0; overdrive = 0; tick(2);
    // bus reset
    bus_reset = 1; en_wr = 1; en_wdata = 1; tick(1); bus_reset = 0; en_wr = 0;
    chk(irq_en, 0, "R4 bus reset wins");
    charge = 16'd1000; tick(3); chk(bus_pull, 0, "R4 no fire after reset");
    charge = 0; tick(2);
    // sleep
    en_wr = 1; en_wdata = 1; tick(1); en_wr = 0;
    route_bus = 0; charge = 16'd1000; tick(1); chk(pin_pull, 1, "R5 pin again");
    asleep = 1; tick(1); chk(pin_pull, 0, "R10 sleep releases pin"); asleep = 0;
    charge = 0; tick(2);
    pin_wr = 1; pin_wdata = 0; tick(1); pin_wr = 0; chk(pin_pull, 1, "R9 low again");
    bus_low_to = 1; tick(1); chk(pin_pull, 0, "R10 bus timeout release"); bus_low_to = 0;
    route_bus = 1; charge = 16'd1000; tick(1); chk(bus_pull, 1, "R10 pulse started");
    asleep = 1; tick(1); chk(bus_pull, 0, "R10 sleep aborts pulse"); asleep = 0;
    charge = 0; tick(3);
    done = 1;
    report();
  end
endmodule